// File: doc/BRIEF.md
# Ethernet Multicast Hash Filter

This block judges, one destination address at a time, whether a received Ethernet frame should be kept. The six destination bytes arrive one per valid cycle in wire order. While they stream in, a CRC-32 is accumulated over them. The six most significant bits of the finished CRC pick one bin out of a 64-bin hash table. The decision combines that bin with the address class (broadcast, group, own station) and four receive control bits. It produces one accept flag and three class flags, marked by a single-cycle done strobe.

Software loads the 64-bit table through two 32-bit word writes. A layout select input chooses between two orders. In the straight order, word select 0 carries the lower half of the table. In the swapped order, the two halves trade places and the four bytes inside each word are reversed.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, `done`, `accept`, `is_bcast`, `is_phys` and `is_mcast` are all 0, and every table bin is 0.
- R2: The hash is computed as follows. The CRC starts at all ones. Each byte is fed bit 0 first: feedback = CRC[31] xor data bit, then the CRC shifts left one place and, when feedback is 1, is xored with 0x04C11DB7. No final inversion or reflection is applied. The bin index is CRC[31:26] after the sixth byte.
- R3: With `layout_swap`=0, a write with `tbl_wr_sel`=0 loads table bins 31:0 and a write with `tbl_wr_sel`=1 loads bins 63:32. Bit i of the written word lands in bin 32*sel+i.
- R4: With `layout_swap`=1, a write with `tbl_wr_sel`=0 loads bins 63:32 and a write with `tbl_wr_sel`=1 loads bins 31:0. In both cases data byte k (bits 8k+7:8k) is stored as byte 3-k of that half, so data bits 7:0 land in bins 63:56 for select 0.
- R5: An address of all ones is broadcast. For a broadcast frame, `is_bcast` is 1 and the frame is accepted only when `rx_ctl[3]` or `rx_ctl[0]` is set. The hash table is not consulted.
- R6: A frame whose first byte has bit 0 set and that is not broadcast is multicast. For such a frame, `is_mcast` is 1 and the frame is accepted only when `rx_ctl[2]` is set and the indexed table bin is 1, or when `rx_ctl[0]` is set.
- R7: A frame whose first byte has bit 0 clear and whose address equals `station_addr` sets `is_phys`. Byte k of the address sits at `station_addr[8k+7:8k]`, with byte 0 sent first. Such a frame is accepted when `rx_ctl[1]` is set. A non-matching individual address sets no class flag and is rejected unless `rx_ctl[0]` is set.
- R8: `rx_ctl[0]` set accepts every frame, whatever its class, the table contents or the other control bits.
- R9: `done` pulses for exactly one cycle, in the cycle after the sixth byte is taken. The verdict outputs then hold their value until the next `done`. Control inputs and the table are sampled in the sixth-byte cycle.
- R10: `sof` abandons any partial frame and restarts byte counting and the CRC. A byte presented in the same cycle as `sof` is the first byte of the new frame.
- R11: Bytes beyond the sixth are ignored until the next `sof`. They produce no further `done` and do not alter the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| layout_swap | input | 1 | Table word layout select (0 straight, 1 swapped) |
| tbl_wr_en | input | 1 | Table word write strobe |
| tbl_wr_sel | input | 1 | Table word select |
| tbl_wr_data | input | 32 | Table word data |
| rx_ctl | input | 4 | bit0 accept all, bit1 own station, bit2 multicast, bit3 broadcast |
| station_addr | input | 48 | Own station address, byte 0 in bits 7:0 |
| sof | input | 1 | Start-of-frame pulse |
| byte_vld | input | 1 | Address byte valid |
| byte_data | input | 8 | Address byte |
| done | output | 1 | Verdict strobe |
| accept | output | 1 | Frame accepted |
| is_bcast | output | 1 | Broadcast address received |
| is_phys | output | 1 | Own station address matched |
| is_mcast | output | 1 | Multicast address received |

## Verification
The hardest situation to reach is a multicast frame landing on one specific bin chosen in advance, because the bin is a scrambled function of the address. The bench therefore carries its own CRC model and searches the address space for an address that lands on the wanted bin, for example a bin in 63:56 that only byte 0 of a swapped-layout write can reach. It then sets exactly that bin and checks that the frame is accepted. Broadcast frames against an all-ones table, and a `sof` arriving in the middle of a frame, cover the priority and restart cases.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
   localparam int CTL_ALL   = 0;
   localparam int CTL_PHYS  = 1;
   localparam int CTL_MCAST = 2;
   localparam int CTL_BCAST = 3;
   localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

   typedef struct packed {
      logic accept;
      logic bcast;
      logic phys;
      logic mcast;
   } verdict_t;

   // one byte into the CRC, bit 0 first, no reflection
   function automatic logic [31:0] crc_feed_byte(input logic [31:0] c_in,
                                                 input logic [7:0]  d);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[31] ^ d[i];
         c  = {c[30:0], 1'b0};
         if (fb) c = c ^ CRC_POLY;
      end
      return c;
   endfunction
endpackage

// File: rtl/mhf_addr_track.sv
module mhf_addr_track #(
   parameter int N_BYTES = 6,
   localparam int CW = $clog2(N_BYTES + 1),
   localparam int AW = 8 * N_BYTES
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sof,
   input  logic          byte_vld,
   input  logic [7:0]    byte_data,
   output logic          take,
   output logic          last,
   output logic [AW-1:0] addr_now
);
   logic [CW-1:0] cnt_q, cnt_base;
   logic [AW-1:0] hold_q;

   assign cnt_base = sof ? '0 : cnt_q;
   assign take     = byte_vld && (cnt_base < CW'(N_BYTES));
   assign last     = take && (cnt_base == CW'(N_BYTES - 1));

   always_comb begin
      addr_now = sof ? '0 : hold_q;
      for (int k = 0; k < N_BYTES; k++)
         if (take && cnt_base == CW'(k)) addr_now[8*k +: 8] = byte_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         hold_q <= '0;
      end else if (sof || take) begin
         cnt_q  <= cnt_base + CW'(take);
         hold_q <= addr_now;
      end
   end

   // R11: counter never runs past the address length
   a_r11_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(N_BYTES));
   // R10: sof with a byte makes that byte the first one
   a_r10_sof_first_byte: assert property (@(posedge clk) disable iff (!rst_n)
      sof && byte_vld |=> cnt_q == CW'(1));
   // R11: a byte after a complete address leaves the held address alone
   a_r11_extra_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      !sof && byte_vld && cnt_q == CW'(N_BYTES) |=> $stable(hold_q));
endmodule

// File: rtl/mhf_crc_unit.sv
module mhf_crc_unit (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sof,
   input  logic        take,
   input  logic [7:0]  byte_data,
   output logic [31:0] crc_next
);
   import mhf_pkg::*;
   logic [31:0] crc_q, crc_base;

   assign crc_base = sof ? '1 : crc_q;
   assign crc_next = take ? crc_feed_byte(crc_base, byte_data) : crc_base;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) crc_q <= '1;
      else        crc_q <= crc_next;
   end

   // R10: a bare sof reseeds the CRC to all ones
   a_r10_seed: assert property (@(posedge clk) disable iff (!rst_n)
      sof && !take |=> crc_q == 32'hFFFF_FFFF);
   // R11: no byte taken, CRC unchanged
   a_r11_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sof && !take |=> $stable(crc_q));
endmodule

// File: rtl/mhf_hash_table.sv
module mhf_hash_table #(
   parameter int HASH_BITS = 6,
   parameter int WORD_W    = 32,
   localparam int TBL      = 2 ** HASH_BITS,
   localparam int NWORDS   = TBL / WORD_W,
   localparam int SELW     = (NWORDS > 1) ? $clog2(NWORDS) : 1,
   localparam int NB       = WORD_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [SELW-1:0]      wr_sel,
   input  logic [WORD_W-1:0]    wr_data,
   input  logic                 layout_swap,
   input  logic [HASH_BITS-1:0] rd_idx,
   output logic                 rd_bit
);
   if (TBL % WORD_W != 0 || WORD_W % 8 != 0) begin : g_bad_geometry
      $error("table size must be a multiple of the word, word a multiple of 8");
   end

   logic [WORD_W-1:0] data_rev;
   logic [TBL-1:0]    tbl_flat;

   for (genvar b = 0; b < NB; b++) begin : g_rev
      assign data_rev[8*b +: 8] = wr_data[8*(NB-1-b) +: 8];
   end

   for (genvar w = 0; w < NWORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic              hit;
      assign hit = wr_en && (layout_swap ? (wr_sel == SELW'(NWORDS - 1 - w))
                                         : (wr_sel == SELW'(w)));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q <= '0;
         else if (hit) word_q <= layout_swap ? data_rev : wr_data;
      end
      assign tbl_flat[w*WORD_W +: WORD_W] = word_q;
   end

   assign rd_bit = tbl_flat[rd_idx];

   // R3: straight layout, select 0 fills the low word
   a_r3_plain_low: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !layout_swap && wr_sel == '0 |=> tbl_flat[WORD_W-1:0] == $past(wr_data));
   // R4: swapped layout, select 0 data byte 0 lands in the top byte
   a_r4_swap_top_byte: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && layout_swap && wr_sel == '0 |=> tbl_flat[TBL-1 -: 8] == $past(wr_data[7:0]));
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
   parameter int N_BYTES   = 6,
   parameter int HASH_BITS = 6,
   parameter int WORD_W    = 32,
   localparam int AW       = 8 * N_BYTES,
   localparam int NWORDS   = (2 ** HASH_BITS) / WORD_W,
   localparam int SELW     = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              layout_swap,
   input  logic              tbl_wr_en,
   input  logic [SELW-1:0]   tbl_wr_sel,
   input  logic [WORD_W-1:0] tbl_wr_data,
   input  logic [3:0]        rx_ctl,
   input  logic [AW-1:0]     station_addr,
   input  logic              sof,
   input  logic              byte_vld,
   input  logic [7:0]        byte_data,
   output logic              done,
   output logic              accept,
   output logic              is_bcast,
   output logic              is_phys,
   output logic              is_mcast
);
   import mhf_pkg::*;

   if (HASH_BITS < 1 || HASH_BITS > 32) begin : g_bad_hash
      $error("hash index must take 1 to 32 CRC bits");
   end

   logic                 take, last, bin_hit;
   logic [AW-1:0]        addr_now;
   logic [31:0]          crc_next;
   logic [HASH_BITS-1:0] bin_idx;
   verdict_t             vd_next, vd_q;
   logic                 done_q;

   mhf_addr_track #(.N_BYTES(N_BYTES)) u_track (
      .clk, .rst_n, .sof, .byte_vld, .byte_data,
      .take, .last, .addr_now);

   mhf_crc_unit u_crc (
      .clk, .rst_n, .sof, .take, .byte_data, .crc_next);

   assign bin_idx = crc_next[31 -: HASH_BITS];

   mhf_hash_table #(.HASH_BITS(HASH_BITS), .WORD_W(WORD_W)) u_table (
      .clk, .rst_n, .wr_en(tbl_wr_en), .wr_sel(tbl_wr_sel), .wr_data(tbl_wr_data),
      .layout_swap, .rd_idx(bin_idx), .rd_bit(bin_hit));

   always_comb begin
      logic grp;
      grp           = addr_now[0];
      vd_next.bcast = &addr_now;
      vd_next.mcast = grp && !vd_next.bcast;
      vd_next.phys  = !grp && (addr_now == station_addr);
      // broadcast decided before the hash is looked at
      if (vd_next.bcast)      vd_next.accept = rx_ctl[CTL_BCAST];
      else if (vd_next.mcast) vd_next.accept = rx_ctl[CTL_MCAST] && bin_hit;
      else                    vd_next.accept = vd_next.phys && rx_ctl[CTL_PHYS];
      if (rx_ctl[CTL_ALL]) vd_next.accept = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         vd_q   <= '0;
      end else begin
         done_q <= last;
         if (last) vd_q <= vd_next;
      end
   end

   assign done     = done_q;
   assign accept   = vd_q.accept;
   assign is_bcast = vd_q.bcast;
   assign is_phys  = vd_q.phys;
   assign is_mcast = vd_q.mcast;

   // R9: done never lasts two cycles
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: verdict holds between strobes
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(accept));
   // R8: accept-all wins
   a_r8_accept_all: assert property (@(posedge clk) disable iff (!rst_n)
      done && $past(rx_ctl[CTL_ALL]) |-> accept);
   // R5: at most one class flag per frame
   a_r5_one_class: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $countones({is_bcast, is_phys, is_mcast}) <= 1);
   // R6: multicast without its enable is dropped
   a_r6_mcast_gate: assert property (@(posedge clk) disable iff (!rst_n)
      done && is_mcast && !$past(rx_ctl[CTL_ALL]) && !$past(rx_ctl[CTL_MCAST]) |-> !accept);
endmodule

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
   typedef struct {
      logic [3:0] vd;   // {accept, bcast, phys, mcast}
      string      req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        layout_swap = 1'b0;
   logic        tbl_wr_en = 1'b0;
   logic [0:0]  tbl_wr_sel = 1'b0;
   logic [31:0] tbl_wr_data = '0;
   logic [3:0]  rx_ctl = '0;
   logic [47:0] station_addr = 48'h66_55_44_33_22_10;
   logic        sof = 1'b0, byte_vld = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        done, accept, is_bcast, is_phys, is_mcast;

   int    n_checks = 0, n_fail = 0;
   bit    finished = 0;
   exp_t  sb_q[$];
   logic [63:0] m_tab = '0;

   always #2 clk = ~clk;

   mcast_hash_filter u_mcast_hash_filter (
      .clk, .rst_n, .layout_swap, .tbl_wr_en, .tbl_wr_sel, .tbl_wr_data,
      .rx_ctl, .station_addr, .sof, .byte_vld, .byte_data,
      .done, .accept, .is_bcast, .is_phys, .is_mcast);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // R2 model of the bin index
   function automatic int bin_of(logic [47:0] a);
      logic [31:0] c = '1;
      logic fb;
      for (int b = 0; b < 6; b++)
         for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ a[8*b+i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
         end
      return int'(c[31:26]);
   endfunction

   function automatic logic [3:0] expect_of(logic [47:0] a);
      logic bc, mc, ph, acc;
      bc = &a;
      mc = a[0] && !bc;
      ph = !a[0] && (a == station_addr);
      if (bc)      acc = rx_ctl[3];
      else if (mc) acc = rx_ctl[2] && m_tab[bin_of(a)];
      else         acc = ph && rx_ctl[1];
      if (rx_ctl[0]) acc = 1'b1;
      return {acc, bc, ph, mc};
   endfunction

   task automatic wr_word(logic sel, logic [31:0] d);
      logic [31:0] v;
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_sel = sel; tbl_wr_data = d;
      v = layout_swap ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
      if (sel ^ layout_swap) m_tab[63:32] = v;
      else                   m_tab[31:0]  = v;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   task automatic send_frame(logic [47:0] a, int extra, string req);
      exp_t e;
      e.vd = expect_of(a); e.req = req;
      sb_q.push_back(e);
      for (int b = 0; b < 6; b++) begin
         @(negedge clk);
         sof = (b == 0); byte_vld = 1'b1; byte_data = a[8*b +: 8];
      end
      for (int x = 0; x < extra; x++) begin
         @(negedge clk);
         sof = 1'b0; byte_vld = 1'b1; byte_data = 8'hFF ^ 8'(x);
      end
      @(negedge clk);
      sof = 1'b0; byte_vld = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_partial(logic [47:0] a, int n);
      for (int b = 0; b < n; b++) begin
         @(negedge clk);
         sof = (b == 0); byte_vld = 1'b1; byte_data = a[8*b +: 8];
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb_q.size() == 0) check("R9 unexpected done", 32'd1, 32'd0);
         else begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, {28'd0, accept, is_bcast, is_phys, is_mcast}, {28'd0, e.vd});
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++; n_checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [47:0] a;
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {27'd0, done, accept, is_bcast, is_phys, is_mcast}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: table empty, multicast with enable rejected
      rx_ctl = 4'b0100;
      send_frame(48'h00_00_01_5E_00_01, 0, "R1 empty table");

      // R7 own station
      rx_ctl = 4'b0000;
      send_frame(station_addr, 0, "R7 station no enable");
      rx_ctl = 4'b0010;
      send_frame(station_addr, 0, "R7 station accepted");
      send_frame(48'h66_55_44_33_22_12, 0, "R7 other unicast");

      // R5 broadcast
      send_frame('1, 0, "R5 bcast no enable");
      rx_ctl = 4'b1000;
      send_frame('1, 0, "R5 bcast accepted");
      wr_word(1'b0, '1); wr_word(1'b1, '1);
      rx_ctl = 4'b0100;
      send_frame('1, 0, "R5 bcast ignores hash");

      // R2 / R3 straight layout pattern
      wr_word(1'b0, 32'hA5A5_F00F); wr_word(1'b1, 32'h3C3C_1234);
      for (int j = 0; j < 16; j++)
         send_frame({8'(j * 37), 8'h34, 8'h12, 8'h5E, 8'h00, 8'h01}, 0, "R2 R3 hash straight");
      rx_ctl = 4'b0000;
      for (int j = 0; j < 4; j++)
         send_frame({8'(j), 8'h77, 8'h12, 8'h5E, 8'h00, 8'h01}, 0, "R6 mcast disabled");

      // R4 swapped layout
      layout_swap = 1'b1;
      rx_ctl = 4'b0100;
      wr_word(1'b0, 32'h0000_0000); wr_word(1'b1, 32'h0000_0000);
      a = '0;
      for (int j = 0; j < 256; j++) begin
         a = {8'(j), 8'h9A, 8'h12, 8'h5E, 8'h00, 8'h03};
         if (bin_of(a) >= 56) break;
      end
      send_frame(a, 0, "R4 bin clear before write");
      wr_word(1'b0, 32'h1 << (bin_of(a) - 56));
      check("R4 model bin set", {31'd0, m_tab[bin_of(a)]}, 32'd1);
      send_frame(a, 0, "R4 swapped byte0 to top bin");
      wr_word(1'b1, 32'h1234_5678); wr_word(1'b0, 32'hC3C3_0FF0);
      for (int j = 0; j < 12; j++)
         send_frame({8'(j * 53), 8'h01, 8'h02, 8'h5E, 8'h00, 8'h01}, 0, "R4 R6 hash swapped");
      layout_swap = 1'b0;

      // R8 accept all
      rx_ctl = 4'b0001;
      wr_word(1'b0, 32'h0); wr_word(1'b1, 32'h0);
      send_frame(48'hAB_CD_EF_01_02_04, 0, "R8 unicast");
      send_frame(48'h00_00_01_5E_00_01, 0, "R8 mcast empty table");
      send_frame('1, 0, "R8 bcast");

      // R11 trailing bytes
      rx_ctl = 4'b0010;
      send_frame(station_addr, 3, "R11 extra bytes");
      check("R11 verdict kept", {31'd0, accept}, 32'd1);

      // R9 hold while controls change
      rx_ctl = 4'b0000;
      repeat (3) @(negedge clk);
      check("R9 hold accept", {30'd0, accept, done}, 32'd2);

      // R10 partial frame abandoned, then back-to-back sof
      rx_ctl = 4'b1010;
      send_partial('1, 3);
      @(negedge clk); byte_vld = 1'b0;
      send_frame(48'h01_02_03_04_05_06, 0, "R10 restart after gap");
      send_partial(station_addr, 4);
      send_frame('1, 0, "R10 sof mid frame");

      repeat (4) @(negedge clk);
      check("R9 all verdicts seen", sb_q.size(), 32'd0);
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule